// File: doc/BRIEF.md
# Flash Block RAM-Overlay Controller

This controller lets one of the four lowest 1 KB flash erase blocks be shadowed by a fixed 1 KB on-chip RAM window. Software can then change code or constants in RAM and run them in place, as if they lived in flash, before committing them to the real array. A control register holds an overlay enable and a two-bit block selector. For every CPU address the block returns a remapped address and a flag that routes the access to RAM instead of flash.

While the overlay is on, the controller also shields the flash from programming and erasing. The program and erase request bits of the flash control register are forced inactive at the mode outputs, whichever block the selector names. Clearing the enable restores normal flash routing and lets pending program or erase requests take effect. Selecting block 0 places the reset and interrupt vectors in the overlay RAM.

Top module: `flash_overlay_ctrl`

## Requirements
- R1: After reset the overlay enable, the selector and both flash request bits are 0, both mode outputs are low, and every address passes through unchanged with ram_sel low.
- R2: A write to register address 0 stores wdata bit 7 as the overlay enable and wdata bits 1:0 as the block selector. A read of address 0 returns {enable, 5'b0, selector}.
- R3: With the overlay enabled, an address whose bits 23:12 are zero and whose bits 11:10 equal the selector maps to 0xFFEC00 plus its low 10 bits, with ram_sel high. This covers offsets 0x000 and 0x3FF of every block.
- R4: With the overlay enabled, an address in one of the other three low blocks passes through unchanged with ram_sel low.
- R5: Addresses at or above 0x001000 always pass through unchanged. With the overlay disabled, all addresses pass through unchanged with ram_sel low.
- R6: A write to register address 1 stores wdata bit 0 as the program request and wdata bit 1 as the erase request. A read of address 1 returns {6'b0, erase, program}.
- R7: prog_mode equals program AND NOT enable, and erase_mode equals erase AND NOT enable. With the overlay enabled, both stay low for any selector value, even after a program or erase request is written.
- R8: Clearing the enable makes held program or erase requests appear on the mode outputs in the cycle after the write, and sends the formerly overlaid block back to flash.
- R9: With selector 0 enabled, address 0x000000, which holds the vectors, maps to 0xFFEC00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 overlay control, 1 flash control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| cpu_addr | input | 24 | CPU access address |
| map_addr | output | 24 | Remapped address |
| ram_sel | output | 1 | High when the access is routed to overlay RAM |
| prog_mode | output | 1 | Flash program mode enable |
| erase_mode | output | 1 | Flash erase mode enable |

## Verification
The assertions assume that reg_wr, reg_addr and reg_wdata are stable around the rising edge, and that cpu_addr only changes well before the edge at which the outputs are sampled. The remap path is combinational, so a mid-cycle change would leave the sampled outputs undefined. The bench changes every input at the falling edge and samples one falling edge later, after the register outputs have settled. Register writes last exactly one cycle, so no value is stored twice.

// File: rtl/flash_ovl_pkg.sv
package flash_ovl_pkg;
    parameter int ADDR_W = 24;
    parameter int BLK_W  = 10;
    parameter int SEL_W  = 2;

    typedef struct packed {
        logic             ovl_en;
        logic [SEL_W-1:0] blk_sel;
        logic             pgm_req;
        logic             ers_req;
    } ovl_state_t;
endpackage

// File: rtl/ovl_regs.sv
module ovl_regs
    import flash_ovl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output ovl_state_t       state
);
    ovl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr) begin
            if (!addr) begin
                state_d.ovl_en  = wdata[7];
                state_d.blk_sel = wdata[SEL_W-1:0];
            end else begin
                state_d.pgm_req = wdata[0];
                state_d.ers_req = wdata[1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        rdata = '0;
        if (!addr) begin
            rdata[7]         = state_q.ovl_en;
            rdata[SEL_W-1:0] = state_q.blk_sel;
        end else begin
            rdata[0] = state_q.pgm_req;
            rdata[1] = state_q.ers_req;
        end
    end

    assign state = state_q;

    // R2: control write lands in the next cycle
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !addr) |=> (state_q.ovl_en == $past(wdata[7]) &&
                           state_q.blk_sel == $past(wdata[SEL_W-1:0])));
    // R6: flash request write lands in the next cycle
    p_flash_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr) |=> (state_q.pgm_req == $past(wdata[0]) &&
                          state_q.ers_req == $past(wdata[1])));
    // R1: without writes the state holds
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(state_q));
endmodule

// File: rtl/ovl_remap.sv
module ovl_remap
    import flash_ovl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RAM_BASE = 24'hFFEC00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovl_en,
    input  logic [SEL_W-1:0]  blk_sel,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [ADDR_W-1:0] map_addr,
    output logic              ram_sel
);
    localparam int NBLK     = 1 << SEL_W;
    localparam int REGION_W = BLK_W + SEL_W;

    logic [NBLK-1:0] blk_hit;
    logic            low_region;

    assign low_region = (cpu_addr[ADDR_W-1:REGION_W] == '0);

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        assign blk_hit[b] = ovl_en && low_region &&
                            (cpu_addr[REGION_W-1:BLK_W] == SEL_W'(b)) &&
                            (blk_sel == SEL_W'(b));
    end

    assign ram_sel  = |blk_hit;
    assign map_addr = ram_sel ? {RAM_BASE[ADDR_W-1:BLK_W], cpu_addr[BLK_W-1:0]}
                              : cpu_addr;

    // at most one block can be overlaid
    p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blk_hit));
    // R3: redirected access keeps its offset inside the RAM window
    p_redirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> (map_addr[ADDR_W-1:BLK_W] == RAM_BASE[ADDR_W-1:BLK_W] &&
                     map_addr[BLK_W-1:0] == cpu_addr[BLK_W-1:0]));
    // R5: disabled overlay never redirects
    p_disabled_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ovl_en |-> (!ram_sel && map_addr == cpu_addr));
endmodule

// File: rtl/ovl_guard.sv
module ovl_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic ovl_en,
    input  logic pgm_req,
    input  logic ers_req,
    output logic prog_mode,
    output logic erase_mode
);
    assign prog_mode  = pgm_req && !ovl_en;
    assign erase_mode = ers_req && !ovl_en;

    // R7: no mode entry while the overlay is active
    p_no_mode_emul_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_en |-> (!prog_mode && !erase_mode));
    // R8: mode appears once the overlay is released
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovl_en && pgm_req) |-> prog_mode);
endmodule

// File: rtl/flash_overlay_ctrl.sv
module flash_overlay_ctrl
    import flash_ovl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [23:0] cpu_addr,
    output logic [23:0] map_addr,
    output logic        ram_sel,
    output logic        prog_mode,
    output logic        erase_mode
);
    ovl_state_t st;

    ovl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .state(st)
    );

    ovl_remap #(.RAM_BASE(24'hFFEC00)) u_remap (
        .clk(clk), .rst_n(rst_n), .ovl_en(st.ovl_en), .blk_sel(st.blk_sel),
        .cpu_addr(cpu_addr), .map_addr(map_addr), .ram_sel(ram_sel)
    );

    ovl_guard u_guard (
        .clk(clk), .rst_n(rst_n), .ovl_en(st.ovl_en), .pgm_req(st.pgm_req),
        .ers_req(st.ers_req), .prog_mode(prog_mode), .erase_mode(erase_mode)
    );
endmodule

// File: tb/flash_overlay_ctrl_tb.sv
module flash_overlay_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic        reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic [23:0] cpu_addr;
    logic [23:0] map_addr;
    logic        ram_sel;
    logic        prog_mode;
    logic        erase_mode;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    localparam logic [23:0] RAMB = 24'hFFEC00;

    always #2 clk = ~clk;

    flash_overlay_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
        .map_addr(map_addr), .ram_sel(ram_sel), .prog_mode(prog_mode),
        .erase_mode(erase_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic probe(input string req, input logic [23:0] a,
                         input logic [23:0] exp_a, input logic exp_r);
        @(negedge clk);
        cpu_addr = a;
        #1;
        check(req, {8'h0, map_addr}, {8'h0, exp_a});
        check(req, {31'h0, ram_sel}, {31'h0, exp_r});
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd_reg(1'b0, d); check("R1 ctrl", {24'h0, d}, 32'h0);
        rd_reg(1'b1, d); check("R1 flash", {24'h0, d}, 32'h0);
        check("R1 prog", {31'h0, prog_mode}, 32'h0);
        check("R1 erase", {31'h0, erase_mode}, 32'h0);
        probe("R1 pass", 24'h000400, 24'h000400, 1'b0);
    endtask

    task automatic t_remap_all;
        logic [7:0] d;
        for (int s = 0; s < 4; s++) begin
            wr_reg(1'b0, 8'h80 | 8'(s) | 8'h7C);
            rd_reg(1'b0, d);
            check("R2 readback", {24'h0, d}, {24'h0, 8'h80 | 8'(s)});
            for (int b = 0; b < 4; b++) begin
                logic [23:0] base = 24'(b) << 10;
                if (b == s) begin
                    probe("R3 low", base, RAMB, 1'b1);
                    probe("R3 high", base | 24'h3FF, RAMB | 24'h3FF, 1'b1);
                end else begin
                    probe("R4 low", base, base, 1'b0);
                    probe("R4 high", base | 24'h3FF, base | 24'h3FF, 1'b0);
                end
            end
            probe("R5 above", 24'h001000 | (24'(s) << 10), 24'h001000 | (24'(s) << 10), 1'b0);
            probe("R5 top", 24'hFFEC05, 24'hFFEC05, 1'b0);
        end
    endtask

    task automatic t_vector;
        wr_reg(1'b0, 8'h80);
        probe("R9 vector", 24'h000000, RAMB, 1'b1);
        probe("R9 vector odd", 24'h000006, RAMB | 24'h6, 1'b1);
    endtask

    task automatic t_disabled;
        wr_reg(1'b0, 8'h01);
        probe("R5 disabled", 24'h000400, 24'h000400, 1'b0);
        probe("R5 disabled b0", 24'h000000, 24'h000000, 1'b0);
    endtask

    task automatic t_protect;
        logic [7:0] d;
        for (int s = 0; s < 4; s++) begin
            wr_reg(1'b0, 8'h80 | 8'(s));
            wr_reg(1'b1, 8'h03);
            rd_reg(1'b1, d);
            check("R6 readback", {24'h0, d}, 32'h3);
            check("R7 prog", {31'h0, prog_mode}, 32'h0);
            check("R7 erase", {31'h0, erase_mode}, 32'h0);
            wr_reg(1'b1, 8'h00);
        end
        wr_reg(1'b1, 8'h01);
        check("R7 prog only", {31'h0, prog_mode}, 32'h0);
        // release overlay (selector 3 still held)
        wr_reg(1'b0, 8'h03);
        check("R8 prog", {31'h0, prog_mode}, 32'h1);
        check("R8 erase", {31'h0, erase_mode}, 32'h0);
        probe("R8 flash back", 24'h000C10, 24'h000C10, 1'b0);
        wr_reg(1'b1, 8'h02);
        check("R7 erase plain", {31'h0, erase_mode}, 32'h1);
        check("R7 prog plain", {31'h0, prog_mode}, 32'h0);
        wr_reg(1'b0, 8'h83);
        check("R7 erase gated", {31'h0, erase_mode}, 32'h0);
    endtask

    initial begin
        #40000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0; cpu_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_remap_all();
        t_vector();
        t_disabled();
        t_protect();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule